// File: doc/BRIEF.md
# Dual-Timer Register Interface with Shared Interrupt

This block sits between a byte-wide host bus and two timer channels. It decodes a 3-bit address, qualified by chip select and separate write and read strobes, into single-cycle write pulses for each channel's reload value (high byte and low byte) and control byte. It steers the channels' live count snapshots back onto the read data bus. The channels' counting logic lives elsewhere; each channel reports a one-cycle timeout event into this block.

The block keeps one latched timeout flag per channel and a shared active-low interrupt line. A timeout always sets the channel's flag. It asserts the interrupt only when that channel's interrupt-enable bit is set. Software reads both flags through either control-byte address, which is otherwise write-only. Writing a channel's control byte clears that channel's flag and interrupt contribution and leaves the other channel alone.

A write is committed in the cycle after the write strobe drops, using the address, data and chip select captured while the strobe was high.

Top module: `dual_timer_bus_if`

## Requirements
- R1: The address map uses addr[2] as the channel (0 = A, 1 = B) and addr[1:0] as the slot: 0 = reload high byte, 1 = reload low byte, 2 = control byte, 3 = unused. A committed write raises exactly one pulse for one cycle, on jam_msb_we_o[ch], jam_lsb_we_o[ch] or ctrl_we_o[ch]. wdata_o carries the written byte in that cycle.
- R2: A write commits only in the first cycle with wr_i low after one or more cycles with wr_i high, and only if cs_i was high in the last strobe-high cycle. No pulse is raised while wr_i is high. Nothing is raised for chip select low or for slot 3.
- R3: While cs_i and rd_i are both high, slot 0 returns bits 15:8 and slot 1 returns bits 7:0 of the addressed channel's snapshot (channel A in hold_i[15:0], B in hold_i[31:16]). Slot 3 returns 0. Without both cs_i and rd_i, rdata_o is 0.
- R4: A read of slot 2 of either channel returns the status byte: bit 7 = channel A timeout flag, bit 6 = channel B timeout flag, bits 5:0 = 0.
- R5: A cycle with tmo_i[ch] high sets that channel's status flag at the next clock edge. If the channel's interrupt enable is 1, irq_n_o goes low from that edge.
- R6: A timeout on a channel whose interrupt enable is 0 leaves irq_n_o unchanged.
- R7: A committed control write to a channel clears that channel's status flag and interrupt contribution at the next edge. The other channel's flag and contribution are unchanged.
- R8: If a timeout and a committed control write for the same channel fall in the same cycle, the flag and the interrupt contribution end up set.
- R9: Active-low reset forces irq_n_o high, clears both status flags and clears both interrupt enables.
- R10: A channel's interrupt enable is bit 4 of the last byte written to its control slot. The enable used for a timeout is the one in force before a control write in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_i | input | 1 | Chip select, active high |
| wr_i | input | 1 | Write strobe, committed on its falling edge |
| rd_i | input | 1 | Read strobe, active high |
| addr_i | input | 3 | Register address |
| data_i | input | 8 | Write data |
| hold_i | input | 32 | Count snapshots, channel A low half, B high half |
| tmo_i | input | 2 | One-cycle timeout events, bit 0 = A, bit 1 = B |
| rdata_o | output | 8 | Read data, 0 when not reading |
| wdata_o | output | 8 | Committed write byte |
| jam_msb_we_o | output | 2 | Reload high-byte write pulse per channel |
| jam_lsb_we_o | output | 2 | Reload low-byte write pulse per channel |
| ctrl_we_o | output | 2 | Control byte write pulse per channel |
| irq_n_o | output | 1 | Shared interrupt, active low |

## Verification
The assertions assume that timeout events and strobes are synchronous to clk and do not change between edges. They also assume that address, data and chip select are held while wr_i is high. The stimulus changes every input only on the falling clock edge, and it holds address and chip select from the strobe-high cycle through the commit cycle. Each timeout is a single-cycle pulse. The bench also lines up a timeout exactly with a commit cycle to exercise the set-wins rule.

// File: rtl/dtb_pkg.sv
package dtb_pkg;
  parameter int DW     = 8;
  parameter int CW     = 16;
  parameter int AW     = 3;
  parameter int NCH    = 2;
  parameter int IE_BIT = 4;
  localparam int CH_W   = (NCH > 1) ? $clog2(NCH) : 1;
  localparam int SLOT_W = AW - CH_W;

  typedef enum logic [SLOT_W-1:0] {
    SLOT_MSB  = 2'd0,
    SLOT_LSB  = 2'd1,
    SLOT_CTRL = 2'd2,
    SLOT_NONE = 2'd3
  } slot_e;

  function automatic logic [CH_W-1:0] chan_of(input logic [AW-1:0] a);
    return a[AW-1 -: CH_W];
  endfunction

  function automatic slot_e slot_of(input logic [AW-1:0] a);
    return slot_e'(a[SLOT_W-1:0]);
  endfunction

  // Channel c owns status bit DW-1-c; the rest of the byte reads 0.
  function automatic logic [DW-1:0] status_byte(input logic [NCH-1:0] st);
    logic [DW-1:0] b;
    b = '0;
    for (int c = 0; c < NCH; c++) b[DW-1-c] = st[c];
    return b;
  endfunction

  function automatic logic [DW-1:0] hold_byte(input logic [CW-1:0] w, input logic hi);
    return hi ? w[CW-1 -: DW] : w[DW-1:0];
  endfunction
endpackage

// File: rtl/dtb_wr_decode.sv
module dtb_wr_decode
  import dtb_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cs_i,
  input  logic           wr_i,
  input  logic [AW-1:0]  addr_i,
  input  logic [DW-1:0]  data_i,
  output logic [DW-1:0]  wdata_o,
  output logic [NCH-1:0] msb_we_o,
  output logic [NCH-1:0] lsb_we_o,
  output logic [NCH-1:0] ctrl_we_o,
  output logic           commit_o
);
  logic          wr_q, cs_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] data_q;

  // Capture the bus while the strobe is high; the last capture wins.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q   <= 1'b0;
      cs_q   <= 1'b0;
      addr_q <= '0;
      data_q <= '0;
    end else begin
      wr_q <= wr_i;
      if (wr_i) begin
        cs_q   <= cs_i;
        addr_q <= addr_i;
        data_q <= data_i;
      end
    end
  end

  assign commit_o = wr_q && !wr_i && cs_q;
  assign wdata_o  = data_q;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic hit;
    assign hit          = commit_o && (chan_of(addr_q) == CH_W'(c));
    assign msb_we_o[c]  = hit && (slot_of(addr_q) == SLOT_MSB);
    assign lsb_we_o[c]  = hit && (slot_of(addr_q) == SLOT_LSB);
    assign ctrl_we_o[c] = hit && (slot_of(addr_q) == SLOT_CTRL);
  end
endmodule

// File: rtl/dtb_chan_flags.sv
module dtb_chan_flags
  import dtb_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic tmo_i,
  input  logic clr_i,
  input  logic ie_new_i,
  output logic ie_o,
  output logic stat_o,
  output logic pend_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ie_o   <= 1'b0;
      stat_o <= 1'b0;
      pend_o <= 1'b0;
    end else begin
      if (clr_i) ie_o <= ie_new_i;
      // Set takes priority over the clearing control write.
      if (tmo_i)      stat_o <= 1'b1;
      else if (clr_i) stat_o <= 1'b0;
      if (tmo_i && ie_o) pend_o <= 1'b1;
      else if (clr_i)    pend_o <= 1'b0;
    end
  end
endmodule

// File: rtl/dtb_rd_mux.sv
module dtb_rd_mux
  import dtb_pkg::*;
(
  input  logic              cs_i,
  input  logic              rd_i,
  input  logic [AW-1:0]     addr_i,
  input  logic [NCH*CW-1:0] hold_i,
  input  logic [NCH-1:0]    stat_i,
  output logic [DW-1:0]     rdata_o
);
  logic [CH_W-1:0] ch;
  logic [CW-1:0]   word;

  assign ch   = chan_of(addr_i);
  assign word = hold_i[int'(ch)*CW +: CW];

  always_comb begin
    rdata_o = '0;
    if (cs_i && rd_i) begin
      case (slot_of(addr_i))
        SLOT_MSB:  rdata_o = hold_byte(word, 1'b1);
        SLOT_LSB:  rdata_o = hold_byte(word, 1'b0);
        SLOT_CTRL: rdata_o = status_byte(stat_i);
        default:   rdata_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/dual_timer_bus_if.sv
module dual_timer_bus_if
  import dtb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [AW-1:0]     addr_i,
  input  logic [DW-1:0]     data_i,
  input  logic [NCH*CW-1:0] hold_i,
  input  logic [NCH-1:0]    tmo_i,
  output logic [DW-1:0]     rdata_o,
  output logic [DW-1:0]     wdata_o,
  output logic [NCH-1:0]    jam_msb_we_o,
  output logic [NCH-1:0]    jam_lsb_we_o,
  output logic [NCH-1:0]    ctrl_we_o,
  output logic              irq_n_o
);
  // Named internal events for the checker.
  logic           commit_w;
  logic [NCH-1:0] ie_w, stat_w, pend_w;

  dtb_wr_decode i_dec (
    .clk(clk), .rst_n(rst_n), .cs_i(cs_i), .wr_i(wr_i),
    .addr_i(addr_i), .data_i(data_i), .wdata_o(wdata_o),
    .msb_we_o(jam_msb_we_o), .lsb_we_o(jam_lsb_we_o),
    .ctrl_we_o(ctrl_we_o), .commit_o(commit_w)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_flags
    dtb_chan_flags i_flags (
      .clk(clk), .rst_n(rst_n), .tmo_i(tmo_i[c]), .clr_i(ctrl_we_o[c]),
      .ie_new_i(wdata_o[IE_BIT]), .ie_o(ie_w[c]), .stat_o(stat_w[c]),
      .pend_o(pend_w[c])
    );
  end

  dtb_rd_mux i_rd (
    .cs_i(cs_i), .rd_i(rd_i), .addr_i(addr_i), .hold_i(hold_i),
    .stat_i(stat_w), .rdata_o(rdata_o)
  );

  assign irq_n_o = ~|pend_w;
endmodule

// File: rtl/dtb_checker.sv
module dtb_checker
  import dtb_pkg::*;
(
  input logic           clk,
  input logic           rst_n,
  input logic           cs_i,
  input logic           wr_i,
  input logic           rd_i,
  input logic [NCH-1:0] tmo_i,
  input logic [NCH-1:0] msb_we,
  input logic [NCH-1:0] lsb_we,
  input logic [NCH-1:0] ctrl_we,
  input logic [NCH-1:0] ie,
  input logic [NCH-1:0] stat,
  input logic [NCH-1:0] pend,
  input logic [DW-1:0]  rdata,
  input logic           irq_n
);
  assert_one_pulse_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ctrl_we, lsb_we, msb_we}));

  assert_trailing_edge_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (|{ctrl_we, lsb_we, msb_we}) |-> ($past(wr_i) && !wr_i));

  assert_idle_read_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(cs_i && rd_i) |-> (rdata == '0));

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    localparam int O = (c + 1) % NCH;

    assert_tmo_sets_R5: assert property (@(posedge clk) disable iff (!rst_n)
      tmo_i[c] |=> stat[c]);

    assert_tmo_irq_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (tmo_i[c] && ie[c]) |=> !irq_n);

    assert_disabled_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (tmo_i[c] && !ie[c] && !pend[c]) |=> !pend[c]);

    assert_clear_own_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_we[c] && !tmo_i[c]) |=> (!stat[c] && !pend[c]));

    assert_keep_other_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_we[c] && !tmo_i[O]) |=> (stat[O] == $past(stat[O])));

    assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (tmo_i[c] && ctrl_we[c]) |=> stat[c]);
  end
endmodule

bind dual_timer_bus_if dtb_checker i_chk (
  .clk(clk), .rst_n(rst_n), .cs_i(cs_i), .wr_i(wr_i), .rd_i(rd_i),
  .tmo_i(tmo_i), .msb_we(jam_msb_we_o), .lsb_we(jam_lsb_we_o),
  .ctrl_we(ctrl_we_o), .ie(ie_w), .stat(stat_w), .pend(pend_w),
  .rdata(rdata_o), .irq_n(irq_n_o)
);

// File: tb/test_dual_timer_bus_if.sv
module test_dual_timer_bus_if;
  localparam int CLK_PERIOD = 10;
  localparam int SIG_RD = 0, SIG_IRQ = 1, SIG_WE = 2, SIG_WD = 3;

  typedef struct {
    int          sig;
    logic [15:0] exp;
    string       tag;
  } item_t;

  logic        clk = 0, rst_n = 0, cs = 0, wr = 0, rd = 0;
  logic [2:0]  addr = 0;
  logic [7:0]  data = 0;
  logic [31:0] hold = {16'h5A3C, 16'hA5C3};
  logic [1:0]  tmo = 0;
  logic [7:0]  rdata, wdata;
  logic [1:0]  msb_we, lsb_we, ctrl_we;
  logic        irq_n;

  int checks = 0, errors = 0;
  bit done = 0;
  item_t q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_timer_bus_if i_dual_timer_bus_if (
    .clk(clk), .rst_n(rst_n), .cs_i(cs), .wr_i(wr), .rd_i(rd),
    .addr_i(addr), .data_i(data), .hold_i(hold), .tmo_i(tmo),
    .rdata_o(rdata), .wdata_o(wdata), .jam_msb_we_o(msb_we),
    .jam_lsb_we_o(lsb_we), .ctrl_we_o(ctrl_we), .irq_n_o(irq_n)
  );

  // Monitor: compares every queued expectation shortly after it was pushed.
  initial begin
    forever begin
      @(negedge clk);
      #2;
      while (q.size() > 0) begin
        item_t it;
        logic [15:0] act;
        it = q.pop_front();
        case (it.sig)
          SIG_RD:  act = {8'h0, rdata};
          SIG_IRQ: act = {15'h0, irq_n};
          SIG_WE:  act = {10'h0, ctrl_we, lsb_we, msb_we};
          default: act = {8'h0, wdata};
        endcase
        checks++;
        if (act !== it.exp) begin
          errors++;
          $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
        end
      end
    end
  end

  task automatic expect_val(input int sig, input logic [15:0] e, input string tag);
    item_t it;
    it.sig = sig; it.exp = e; it.tag = tag;
    q.push_back(it);
  endtask

  // Write vector layout: {ctrl[1:0], lsb[1:0], msb[1:0]}
  task automatic bus_write(input logic [2:0] a, input logic [7:0] d, input logic c,
                           input logic [5:0] vec, input string tag);
    @(negedge clk);
    cs = c; addr = a; data = d; wr = 1;
    #1 expect_val(SIG_WE, 16'(6'b0), {tag, " no pulse while strobe high"});
    @(negedge clk);
    wr = 0;
    #1 expect_val(SIG_WE, 16'(vec), tag);
    if (vec != 0) expect_val(SIG_WD, 16'(d), {tag, " data"});
    @(negedge clk);
    cs = 0;
  endtask

  task automatic bus_read(input logic [2:0] a, input logic c, input logic [7:0] e,
                          input string tag);
    @(negedge clk);
    cs = c; rd = 1; addr = a;
    #1 expect_val(SIG_RD, 16'(e), tag);
    @(negedge clk);
    rd = 0; cs = 0;
  endtask

  task automatic chk_irq(input logic e, input string tag);
    @(negedge clk);
    #1 expect_val(SIG_IRQ, 16'(e), tag);
  endtask

  task automatic pulse_tmo(input logic [1:0] m);
    @(negedge clk); tmo = m;
    @(negedge clk); tmo = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1 expect_val(SIG_IRQ, 16'd1, "R9 irq high in reset");
    @(negedge clk); rst_n = 1;
    bus_read(3'd2, 1, 8'h00, "R9 status clear after reset");

    bus_write(3'd0, 8'h12, 1, 6'b000001, "R1 A high byte");
    bus_write(3'd5, 8'h34, 1, 6'b001000, "R1 B low byte");
    bus_write(3'd1, 8'h56, 1, 6'b000100, "R1 A low byte");
    bus_write(3'd4, 8'h78, 1, 6'b000010, "R1 B high byte");
    bus_write(3'd0, 8'h9A, 0, 6'b000000, "R2 chip select low");
    bus_write(3'd3, 8'hBC, 1, 6'b000000, "R2 unused slot 3");
    bus_write(3'd7, 8'hBD, 1, 6'b000000, "R2 unused slot 7");

    bus_read(3'd0, 1, 8'hA5, "R3 A high byte");
    bus_read(3'd1, 1, 8'hC3, "R3 A low byte");
    bus_read(3'd4, 1, 8'h5A, "R3 B high byte");
    bus_read(3'd5, 1, 8'h3C, "R3 B low byte");
    bus_read(3'd3, 1, 8'h00, "R3 unused reads zero");
    bus_read(3'd0, 0, 8'h00, "R3 no chip select reads zero");

    bus_write(3'd2, 8'h10, 1, 6'b010000, "R10 A control ie=1");
    bus_write(3'd6, 8'h00, 1, 6'b100000, "R10 B control ie=0");

    pulse_tmo(2'b10);
    bus_read(3'd2, 1, 8'h40, "R5 B flag set");
    chk_irq(1, "R6 disabled B keeps irq high");

    pulse_tmo(2'b01);
    bus_read(3'd6, 1, 8'hC0, "R4 both flags via B address");
    chk_irq(0, "R5 enabled A drives irq low");

    bus_write(3'd6, 8'h10, 1, 6'b100000, "R7 B control write");
    bus_read(3'd2, 1, 8'h80, "R7 B cleared A kept");
    chk_irq(0, "R7 A contribution kept");

    pulse_tmo(2'b10);
    bus_write(3'd2, 8'h10, 1, 6'b010000, "R7 A control write");
    bus_read(3'd2, 1, 8'h40, "R7 A cleared B kept");
    chk_irq(0, "R7 B contribution kept");
    bus_write(3'd6, 8'h10, 1, 6'b100000, "R7 B control write 2");
    chk_irq(1, "R7 all cleared irq high");
    bus_read(3'd6, 1, 8'h00, "R7 status empty");

    // Timeout lands in the commit cycle of an A control write.
    @(negedge clk); cs = 1; addr = 3'd2; data = 8'h10; wr = 1;
    @(negedge clk); wr = 0; tmo = 2'b01;
    @(negedge clk); tmo = 0; cs = 0;
    bus_read(3'd2, 1, 8'h80, "R8 set wins over clear");
    chk_irq(0, "R8 irq low after set wins");

    @(negedge clk); rst_n = 0;
    #1 expect_val(SIG_IRQ, 16'd1, "R9 irq high on reset");
    @(negedge clk); rst_n = 1;
    bus_read(3'd2, 1, 8'h00, "R9 status cleared");
    pulse_tmo(2'b01);
    chk_irq(1, "R9 enable cleared by reset");
    bus_read(3'd2, 1, 8'h80, "R9 flag still sets");

    bus_write(3'd2, 8'hEF, 1, 6'b010000, "R10 bit4 zero rest ones");
    pulse_tmo(2'b01);
    chk_irq(1, "R10 ie taken from bit 4 only");

    repeat (3) @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule